// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Atomic Set/Clear Writes

This block is a 32-pin general-purpose I/O controller organised as two banks of sixteen pins. Each pin carries eight control bits: drive value, drive enable, open-drain mode, output inversion, pull-up, pull-down, input enable and input inversion. Each bank also has a read-only sample register that returns the inverted and masked pad levels. Bank 1 (pins 16 to 31) uses the same register layout as bank 0, shifted up by 0x80. A pin's index inside its bank is its pin number modulo 16.

Every register write is 32 bits wide and acts as a pair of masks. A one in bit n of the low half sets pin n's control bit. A one in bit n+16 sets up a clear of that bit instead, and the clear takes priority when both are present. Software can therefore change single pins without a read-modify-write, and writes to different pins never disturb each other.

The pad drive is modelled as registered data, output-enable and pull-control vectors, one bit per pin. Register reads return their data one clock after the read strobe.

Top module: `gpio_dual_bank`

## Requirements
- R1: When synchronous reset is applied, every control bit clears to 0. After reset, `pad_out`, `pad_oe`, `pad_pu`, `pad_pd` and `rdata` are all 0.
- R2: A write that has bit n (0 to 15) set in `wdata` sets control bit n of the addressed register. Bits whose set and clear flags are both 0 keep their value.
- R3: A write that has bit n+16 set clears control bit n of the addressed register. When bits n and n+16 are both set, the control bit becomes 0.
- R4: Within a bank, the offsets (`addr[6:0]`) are: drive value 0x00, drive enable 0x04, open-drain 0x08, output invert 0x0C, pull-up 0x18, pull-down 0x1C, input enable 0x20, input invert 0x24, sample 0x30. `addr[7]` selects the bank. Bank 0 holds pins 0 to 15 and bank 1 holds pins 16 to 31, with pin p at bit p mod 16.
- R5: A read strobe in cycle k places data in `rdata` after the edge that ends cycle k. For a control register, `rdata[15:0]` holds the register value and `rdata[31:16]` reads 0. `rdata` is 0 in any cycle that follows a cycle with no read.
- R6: Reading offset 0x30 returns, in bits [15:0], (pad level XOR input invert) AND input enable for the bank's pins, taken from `pad_in` in the read cycle. Bits [31:16] read 0. A write to offset 0x30 changes no control bit.
- R7: For a pin with open-drain off, `pad_out` equals drive value XOR output invert, and `pad_oe` equals drive enable. Both are registered and appear one cycle after the control registers change.
- R8: For a pin with open-drain on, `pad_out` is 0, and `pad_oe` is 1 only when drive enable is 1 and drive value XOR output invert is 0. Otherwise the pad is released. The same one-cycle timing as R7 applies.
- R9: `pad_pu` and `pad_pd` follow the pull-up and pull-down control bits, one cycle after those bits change.
- R10: Any offset not listed in R4 reads as 0, and a write to such an offset changes no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address: bit 7 selects the bank, bits [6:0] select the offset |
| wdata | input | 32 | Write data: [15:0] set mask, [31:16] clear mask |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad levels seen at the pins |
| pad_out | output | 32 | Pad drive data |
| pad_oe | output | 32 | Pad drive enable |
| pad_pu | output | 32 | Pull-up enable per pin |
| pad_pd | output | 32 | Pull-down enable per pin |

## Verification
The embedded properties assume that `addr` and `wdata` are stable and valid in every cycle where `wr_en` or `rd_en` is high. They also assume that reset is held for at least one edge before any access. The stimulus changes all inputs only at the falling edge and holds them for a whole cycle, so every rising edge samples a settled address and data word. `pad_in` is treated as already synchronous to `clk`, so the bench updates it only at the falling edge as well. A cycle-accurate reference model checks the outputs on every cycle. It follows the design through directed set/clear/priority cases on both banks and through a long run of random accesses, including the read-only and unmapped offsets.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int OFS_W  = 7;
  localparam int N_ATTR = 8;

  typedef enum logic [OFS_W-1:0] {
    OFS_VAL  = 7'h00,
    OFS_OE   = 7'h04,
    OFS_OD   = 7'h08,
    OFS_OINV = 7'h0C,
    OFS_PU   = 7'h18,
    OFS_PD   = 7'h1C,
    OFS_IEN  = 7'h20,
    OFS_IINV = 7'h24,
    OFS_SMP  = 7'h30
  } gpio_ofs_e;

  typedef enum logic [2:0] {
    A_VAL, A_OE, A_OD, A_OINV, A_PU, A_PD, A_IEN, A_IINV
  } gpio_attr_e;

  // Returns {hit, attribute index}; hit is 0 for the sample and unmapped offsets.
  function automatic logic [3:0] ofs_to_attr(input logic [OFS_W-1:0] o);
    logic [3:0] r;
    case (o)
      OFS_VAL:  r = {1'b1, A_VAL};
      OFS_OE:   r = {1'b1, A_OE};
      OFS_OD:   r = {1'b1, A_OD};
      OFS_OINV: r = {1'b1, A_OINV};
      OFS_PU:   r = {1'b1, A_PU};
      OFS_PD:   r = {1'b1, A_PD};
      OFS_IEN:  r = {1'b1, A_IEN};
      OFS_IINV: r = {1'b1, A_IINV};
      default:  r = 4'b0000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [2*PINS-1:0] wdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [2*PINS-1:0] rd_word,
  output logic [PINS-1:0]   ctl_val,
  output logic [PINS-1:0]   ctl_oe,
  output logic [PINS-1:0]   ctl_od,
  output logic [PINS-1:0]   ctl_oinv,
  output logic [PINS-1:0]   ctl_pu,
  output logic [PINS-1:0]   ctl_pd
);

  localparam int DW = 2 * PINS;

  logic [PINS-1:0] ctl [N_ATTR];
  logic [3:0]      hit;
  logic [PINS-1:0] set_m, clr_m;
  logic [N_ATTR*PINS-1:0] ctl_flat;

  assign hit   = ofs_to_attr(ofs);
  assign set_m = wdata[PINS-1:0];
  assign clr_m = wdata[DW-1:PINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < N_ATTR; a++) ctl[a] <= '0;
    end else if (wr_en && sel && hit[3]) begin
      ctl[hit[2:0]] <= (ctl[hit[2:0]] | set_m) & ~clr_m;
    end
  end

  always_comb begin
    rd_word = '0;
    if (ofs == OFS_SMP)
      rd_word[PINS-1:0] = (pad_in ^ ctl[A_IINV]) & ctl[A_IEN];
    else if (hit[3])
      rd_word[PINS-1:0] = ctl[hit[2:0]];
  end

  generate
    for (genvar a = 0; a < N_ATTR; a++) begin : g_flat
      assign ctl_flat[a*PINS +: PINS] = ctl[a];
    end
  endgenerate

  assign ctl_val  = ctl[A_VAL];
  assign ctl_oe   = ctl[A_OE];
  assign ctl_od   = ctl[A_OD];
  assign ctl_oinv = ctl[A_OINV];
  assign ctl_pu   = ctl[A_PU];
  assign ctl_pd   = ctl[A_PD];

  // R3
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && ofs == OFS_VAL) |=> ((ctl_val & $past(clr_m)) == '0));

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && ofs == OFS_VAL) |=>
      ((ctl_val & $past(set_m & ~clr_m)) == $past(set_m & ~clr_m)));

  // R10
  no_hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && !hit[3]) |=> $stable(ctl_flat));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] ctl_val,
  input  logic [PINS-1:0] ctl_oe,
  input  logic [PINS-1:0] ctl_od,
  input  logic [PINS-1:0] ctl_oinv,
  input  logic [PINS-1:0] ctl_pu,
  input  logic [PINS-1:0] ctl_pd,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_pu,
  output logic [PINS-1:0] pad_pd
);

  logic [PINS-1:0] eff;
  assign eff = ctl_val ^ ctl_oinv;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '0;
      pad_pd  <= '0;
    end else begin
      pad_out <= eff & ~ctl_od;
      pad_oe  <= ctl_oe & ~(ctl_od & eff);
      pad_pu  <= ctl_pu;
      pad_pd  <= ctl_pd;
    end
  end

  // R8
  od_release_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(ctl_od & (ctl_val ^ ctl_oinv))) == '0));

  // R7
  pushpull_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & ~$past(ctl_od)) == $past(ctl_oe & ~ctl_od)));

endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_pkg::*;
#(
  parameter int PINS_PER_BANK = 16,
  parameter int NUM_BANKS     = 2,
  localparam int BSEL_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = OFS_W + BSEL_W,
  localparam int DW     = 2 * PINS_PER_BANK,
  localparam int NPINS  = NUM_BANKS * PINS_PER_BANK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_pd
);

  localparam int P = PINS_PER_BANK;

  logic [OFS_W-1:0]  ofs;
  logic [BSEL_W-1:0] bsel;
  logic [DW-1:0]     bank_word [NUM_BANKS];

  assign ofs  = addr[OFS_W-1:0];
  assign bsel = addr[ADDR_W-1:OFS_W];

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [P-1:0] c_val, c_oe, c_od, c_oinv, c_pu, c_pd;

      gpio_bank_regs #(.PINS(P)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (bsel == BSEL_W'(b)),
        .ofs     (ofs),
        .wdata   (wdata),
        .pad_in  (pad_in[b*P +: P]),
        .rd_word (bank_word[b]),
        .ctl_val (c_val),
        .ctl_oe  (c_oe),
        .ctl_od  (c_od),
        .ctl_oinv(c_oinv),
        .ctl_pu  (c_pu),
        .ctl_pd  (c_pd)
      );

      gpio_pad_drive #(.PINS(P)) u_drv (
        .clk     (clk),
        .rst     (rst),
        .ctl_val (c_val),
        .ctl_oe  (c_oe),
        .ctl_od  (c_od),
        .ctl_oinv(c_oinv),
        .ctl_pu  (c_pu),
        .ctl_pd  (c_pd),
        .pad_out (pad_out[b*P +: P]),
        .pad_oe  (pad_oe[b*P +: P]),
        .pad_pu  (pad_pu[b*P +: P]),
        .pad_pd  (pad_pd[b*P +: P])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= bank_word[bsel];
    else            rdata <= '0;
  end

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rdata[DW-1:P] == '0));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

endmodule

// File: tb/sim_gpio_dual_bank.sv
module sim_gpio_dual_bank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe, pad_pu, pad_pd;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_dual_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // Reference model: m[bank][attr], attr order val, oe, od, oinv, pu, pd, ien, iinv
  logic [15:0] m [2][8];
  logic [31:0] e_rdata, e_out, e_oe, e_pu, e_pd;
  bit          last_smp;

  function automatic int attr_of(input logic [6:0] o);
    case (o)
      7'h00: return 0;  7'h04: return 1;  7'h08: return 2;  7'h0C: return 3;
      7'h18: return 4;  7'h1C: return 5;  7'h20: return 6;  7'h24: return 7;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) for (int a = 0; a < 8; a++) m[b][a] <= '0;
      e_rdata <= '0; e_out <= '0; e_oe <= '0; e_pu <= '0; e_pd <= '0;
      last_smp <= 0;
    end else begin
      for (int p = 0; p < 32; p++) begin
        int b, i;
        bit eff;
        b = p / 16; i = p % 16;
        eff = m[b][0][i] ^ m[b][3][i];
        if (m[b][2][i]) begin
          e_out[p] <= 1'b0;
          e_oe[p]  <= m[b][1][i] & ~eff;
        end else begin
          e_out[p] <= eff;
          e_oe[p]  <= m[b][1][i];
        end
        e_pu[p] <= m[b][4][i];
        e_pd[p] <= m[b][5][i];
      end
      last_smp <= rd_en && addr[6:0] == 7'h30;
      if (rd_en) begin
        int b, a;
        b = addr[7]; a = attr_of(addr[6:0]);
        if (addr[6:0] == 7'h30)
          e_rdata <= {16'h0, (pad_in[b*16 +: 16] ^ m[b][7]) & m[b][6]};
        else if (a >= 0) e_rdata <= {16'h0, m[b][a]};
        else e_rdata <= '0;
      end else e_rdata <= '0;
      if (wr_en) begin
        int b, a;
        b = addr[7]; a = attr_of(addr[6:0]);
        if (a >= 0) m[b][a] <= (m[b][a] | wdata[15:0]) & ~wdata[31:16];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(last_smp ? "R6 rdata" : "R5 rdata", rdata, e_rdata);
      chk("R7/R8 pad_out", pad_out, e_out);
      chk("R7/R8 pad_oe", pad_oe, e_oe);
      chk("R9 pad_pu", pad_pu, e_pu);
      chk("R9 pad_pd", pad_pd, e_pd);
    end
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: everything idle and zero after reset
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rd(8'h00); rd(8'h84);
    // R2: set mask on bank 0 drive value
    wr(8'h00, 32'h0000_00A5); rd(8'h00);
    wr(8'h00, 32'h0000_0100); rd(8'h00);
    // R3: clear mask, then set and clear on the same pin
    wr(8'h00, 32'h0005_0000); rd(8'h00);
    wr(8'h00, 32'h0002_0002); rd(8'h00);
    // R4: bank 1 layout at 0x80, drive enable and value
    wr(8'h84, 32'h0000_F00F); wr(8'h80, 32'h0000_0F0F); rd(8'h84); rd(8'h04);
    // R7: push-pull with output inversion
    wr(8'h04, 32'h0000_FFFF); wr(8'h8C, 32'h0000_00FF); wr(8'h0C, 32'h0000_3C00);
    // R8: open-drain on both banks
    wr(8'h88, 32'h0000_FFFF); wr(8'h08, 32'h0000_00F0);
    wr(8'h08, 32'hFFFF_0000);
    // R9: pulls
    wr(8'h18, 32'h0000_1234); wr(8'h9C, 32'h0000_8001); wr(8'h18, 32'h0030_0000);
    // R6: sample register with inversion and masking
    pad_in = 32'hA5C3_5A3C;
    wr(8'h20, 32'h0000_FF0F); wr(8'hA0, 32'h0000_0FF0); wr(8'h24, 32'h0000_000F);
    rd(8'h30); rd(8'hB0);
    wr(8'h30, 32'h0000_FFFF); rd(8'h00); rd(8'h30);
    // R10: unmapped offsets
    wr(8'h10, 32'h0000_FFFF); wr(8'hC4, 32'hFFFF_FFFF);
    rd(8'h10); rd(8'hC4); rd(8'h80);
    // Random mix on all offsets
    for (int n = 0; n < 2000; n++) begin
      logic [6:0] ofs_tab [10] = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h18,
                                   7'h1C, 7'h20, 7'h24, 7'h30, 7'h14};
      @(negedge clk);
      wr_en  = ($urandom % 3) != 0;
      rd_en  = ($urandom % 2) != 0;
      addr   = {1'($urandom), ofs_tab[$urandom % 10]};
      wdata  = $urandom;
      pad_in = $urandom;
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule